// File: doc/BRIEF.md
# Floating-Point Exception Status and Control Register

This block is the status and control register of a floating-point unit. When an arithmetic operation completes, the datapath presents a completion strobe with five exception indications: invalid, divide-by-zero, overflow, underflow and inexact. The register replaces its per-operation cause field with these indications. It then ORs the same bits into a sticky flag field, which keeps its earlier set bits until software rewrites it.

If a new cause bit is also enabled, the block raises a trap request for one cycle and presents the trap's exception code. Operations that only approximate their result, such as reciprocal square root, get inexact added automatically when they report nothing else. Software can read and write the whole register. A write stores only the implemented bits. The rounding-mode field and the denormal-control bit are decoded into two select lines for the datapaths.

Top module: `fexc_csr`

## Requirements
- R1: After a synchronous reset, rd_data, rz_sel, flush_sel, trap_req and trap_code are all zero.
- R2: A cycle with sw_we high stores sw_wdata ANDed with 0x0005FFFF. The stored value is visible on rd_data after that clock edge.
- R3: rz_sel is 1 exactly when the rounding-mode field, rd_data[1:0], holds 2'b01. Every other value of that field gives 0 (nearest-even).
- R4: flush_sel equals the denormal-control bit rd_data[18].
- R5: On a completion (op_valid high, sw_we low), the cause field rd_data[16:12] is replaced by the operation's exception bits. op_exc bit order is [4]=invalid, [3]=divide-by-zero, [2]=overflow, [1]=underflow, [0]=inexact, and it maps onto cause bits 16..12 in that order.
- R6: On a completion, the effective exception bits are ORed into the sticky flags rd_data[6:2], with invalid at bit 6 down to inexact at bit 2. Flags that are already set stay set.
- R7: trap_req is high in the cycle after a completion exactly when the new cause ANDed with the enable field rd_data[11:7] is nonzero. The enable field uses the same bit order as the cause field. trap_code shows 0x120 while trap_req is high and 0 otherwise. The request lasts one cycle unless the next operation traps too.
- R8: A completion with no exception bits clears the cause field, leaves the flags unchanged and raises no trap.
- R9: A completion with op_approx high and no exception bits records inexact only (cause 5'b00001). With op_approx high and any exception bit set, the reported bits are used unchanged.
- R10: If sw_we and op_valid are high in the same cycle, the write alone takes effect and no trap is raised.
- R11: Bits 31:19 and bit 17 of rd_data always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation completion strobe |
| op_exc | input | 5 | Exception bits of the completing operation (V,Z,O,U,I) |
| op_approx | input | 1 | Completing operation is an approximation |
| sw_we | input | 1 | Software write enable |
| sw_wdata | input | 32 | Software write data |
| rd_data | output | 32 | Whole register value |
| rz_sel | output | 1 | Round-toward-zero select |
| flush_sel | output | 1 | Flush-denormals-to-zero select |
| trap_req | output | 1 | Floating-point trap request |
| trap_code | output | 12 | Exception code of the trap, zero when idle |

## Verification
The assertions assume that op_exc and op_approx are meaningful only while op_valid is high. They also assume that a cycle after reset is judged against the register value from the previous cycle, never against a value from before reset. The stimulus changes inputs only on the falling edge, one operation or write per cycle. It holds op_valid low on idle cycles. It includes one deliberate collision of a write with a completion, so that the write-wins rule is exercised without relying on any particular order of processes at the clock edge.

// File: rtl/fexc_pkg.sv
package fexc_pkg;

    localparam int XW        = 32;
    localparam int NEXC      = 5;
    localparam int RM_W      = 2;
    localparam int RM_LSB    = 0;
    localparam int FLAG_LSB  = RM_LSB + RM_W;
    localparam int EN_LSB    = FLAG_LSB + NEXC;
    localparam int CAUSE_LSB = EN_LSB + NEXC;
    localparam int DN_BIT    = CAUSE_LSB + NEXC + 1;

    localparam logic [RM_W-1:0] RM_TOWARD_ZERO = 2'b01;
    localparam logic [11:0]     FP_TRAP_CODE   = 12'h120;

    typedef struct packed {
        logic v;
        logic z;
        logic o;
        logic u;
        logic i;
    } exc_t;

    typedef struct packed {
        logic            dn;
        exc_t            cause;
        exc_t            en;
        exc_t            flag;
        logic [RM_W-1:0] rm;
    } csr_t;

    function automatic logic [XW-1:0] csr_pack(csr_t c);
        logic [XW-1:0] w;
        w = '0;
        w[RM_LSB    +: RM_W] = c.rm;
        w[FLAG_LSB  +: NEXC] = c.flag;
        w[EN_LSB    +: NEXC] = c.en;
        w[CAUSE_LSB +: NEXC] = c.cause;
        w[DN_BIT]            = c.dn;
        return w;
    endfunction

    function automatic csr_t csr_unpack(logic [XW-1:0] w);
        csr_t c;
        c.rm    = w[RM_LSB    +: RM_W];
        c.flag  = w[FLAG_LSB  +: NEXC];
        c.en    = w[EN_LSB    +: NEXC];
        c.cause = w[CAUSE_LSB +: NEXC];
        c.dn    = w[DN_BIT];
        return c;
    endfunction

    localparam logic [XW-1:0] IMPL_MASK = csr_pack('1);

endpackage

// File: rtl/fexc_cause_gen.sv
module fexc_cause_gen
    import fexc_pkg::*;
(
    input  exc_t raw_exc,
    input  logic approx,
    output exc_t eff_exc
);
    logic none_reported;

    always_comb begin
        none_reported = (raw_exc == '0);
        eff_exc       = raw_exc;
        if (approx && none_reported) begin
            eff_exc   = '0;
            eff_exc.i = 1'b1;
        end
    end
endmodule

// File: rtl/fexc_trap_eval.sv
module fexc_trap_eval #(
    parameter int N = 5
) (
    input  logic [N-1:0] cause,
    input  logic [N-1:0] enable,
    output logic         hit
);
    logic [N-1:0] per_bit;

    for (genvar k = 0; k < N; k++) begin : g_and
        assign per_bit[k] = cause[k] & enable[k];
    end

    assign hit = |per_bit;
endmodule

// File: rtl/fexc_ctrl_decode.sv
module fexc_ctrl_decode
    import fexc_pkg::*;
(
    input  logic [RM_W-1:0] rm,
    input  logic            dn,
    output logic            rz_sel,
    output logic            flush_sel
);
    always_comb begin
        rz_sel    = (rm == RM_TOWARD_ZERO);
        flush_sel = dn;
    end
endmodule

// File: rtl/fexc_csr.sv
module fexc_csr
    import fexc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          op_valid,
    input  logic [4:0]    op_exc,
    input  logic          op_approx,
    input  logic          sw_we,
    input  logic [31:0]   sw_wdata,
    output logic [31:0]   rd_data,
    output logic          rz_sel,
    output logic          flush_sel,
    output logic          trap_req,
    output logic [11:0]   trap_code
);
    csr_t csr_q, csr_d;
    exc_t eff_exc;
    logic trap_hit;
    logic trap_q, trap_d;

    fexc_cause_gen u_cause (
        .raw_exc (exc_t'(op_exc)),
        .approx  (op_approx),
        .eff_exc (eff_exc)
    );

    fexc_trap_eval #(.N(NEXC)) u_trap (
        .cause  (eff_exc),
        .enable (csr_q.en),
        .hit    (trap_hit)
    );

    fexc_ctrl_decode u_dec (
        .rm        (csr_q.rm),
        .dn        (csr_q.dn),
        .rz_sel    (rz_sel),
        .flush_sel (flush_sel)
    );

    always_comb begin
        csr_d  = csr_q;
        trap_d = 1'b0;
        if (sw_we) begin
            csr_d = csr_unpack(sw_wdata & IMPL_MASK);
        end else if (op_valid) begin
            csr_d.cause = eff_exc;
            csr_d.flag  = csr_q.flag | eff_exc;
            trap_d      = trap_hit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            csr_q  <= '0;
            trap_q <= 1'b0;
        end else begin
            csr_q  <= csr_d;
            trap_q <= trap_d;
        end
    end

    assign rd_data   = csr_pack(csr_q);
    assign trap_req  = trap_q;
    assign trap_code = trap_q ? FP_TRAP_CODE : 12'h000;
endmodule

// File: rtl/fexc_csr_chk.sv
module fexc_csr_chk (
    input logic        clk,
    input logic        rst,
    input logic        op_valid,
    input logic [4:0]  op_exc,
    input logic        op_approx,
    input logic        sw_we,
    input logic [31:0] sw_wdata,
    input logic [31:0] rd_data,
    input logic        rz_sel,
    input logic        flush_sel,
    input logic        trap_req,
    input logic [11:0] trap_code
);
    // R2
    sw_write_masked_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(sw_we) && !$past(rst)) |-> (rd_data == ($past(sw_wdata) & 32'h0005FFFF)));

    // R3
    rz_decode_chk: assert property (@(posedge clk) disable iff (rst)
        rz_sel == (rd_data[1:0] == 2'b01));

    // R4
    flush_decode_chk: assert property (@(posedge clk) disable iff (rst)
        flush_sel == rd_data[18]);

    // R6
    sticky_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(sw_we)) |-> (($past(rd_data[6:2]) & ~rd_data[6:2]) == 5'b0));

    // R7
    trap_source_chk: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> $past(op_valid && !sw_we && !rst));

    // R7
    trap_code_chk: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> (trap_code == 12'h120));

    // R8
    quiet_op_chk: assert property (@(posedge clk) disable iff (rst)
        $past(op_valid && !sw_we && !rst && op_exc == 5'b0 && !op_approx)
        |-> (rd_data[16:12] == 5'b0 && rd_data[6:2] == $past(rd_data[6:2]) && !trap_req));

    // R9
    approx_inexact_chk: assert property (@(posedge clk) disable iff (rst)
        $past(op_valid && !sw_we && !rst && op_exc == 5'b0 && op_approx)
        |-> (rd_data[16:12] == 5'b00001));

    // R10
    write_wins_chk: assert property (@(posedge clk) disable iff (rst)
        $past(sw_we && op_valid) |-> !trap_req);

    // R11
    unused_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data[31:19] == 13'b0) && !rd_data[17]);
endmodule

bind fexc_csr fexc_csr_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_valid  (op_valid),
    .op_exc    (op_exc),
    .op_approx (op_approx),
    .sw_we     (sw_we),
    .sw_wdata  (sw_wdata),
    .rd_data   (rd_data),
    .rz_sel    (rz_sel),
    .flush_sel (flush_sel),
    .trap_req  (trap_req),
    .trap_code (trap_code)
);

// File: tb/tb_fexc_csr.sv
module tb_fexc_csr;
    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [4:0]  op_exc;
    logic        op_approx;
    logic        sw_we;
    logic [31:0] sw_wdata;
    logic [31:0] rd_data;
    logic        rz_sel;
    logic        flush_sel;
    logic        trap_req;
    logic [11:0] trap_code;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    fexc_csr dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_exc(op_exc),
        .op_approx(op_approx), .sw_we(sw_we), .sw_wdata(sw_wdata),
        .rd_data(rd_data), .rz_sel(rz_sel), .flush_sel(flush_sel),
        .trap_req(trap_req), .trap_code(trap_code)
    );

    typedef struct packed {
        logic        we;
        logic [31:0] wd;
        logic        ov;
        logic [4:0]  exc;
        logic        ap;
        logic [31:0] rd;
        logic        tr;
        logic        rz;
        logic        fl;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 32'hFFFF_FFFF, 1'b0, 5'b00000, 1'b0, 32'h0005_FFFF, 1'b0, 1'b0, 1'b1}, // R2 R11 mask
        '{1'b1, 32'h0000_0F81, 1'b0, 5'b00000, 1'b0, 32'h0000_0F81, 1'b0, 1'b1, 1'b0}, // R3 rm=01, all enables
        '{1'b0, 32'h0,         1'b1, 5'b00100, 1'b0, 32'h0000_4F91, 1'b1, 1'b1, 1'b0}, // R5 R7 overflow
        '{1'b0, 32'h0,         1'b1, 5'b00000, 1'b0, 32'h0000_0F91, 1'b0, 1'b1, 1'b0}, // R8 quiet op
        '{1'b0, 32'h0,         1'b1, 5'b00000, 1'b1, 32'h0000_1F95, 1'b1, 1'b1, 1'b0}, // R9 forced inexact
        '{1'b0, 32'h0,         1'b1, 5'b10000, 1'b1, 32'h0001_0FD5, 1'b1, 1'b1, 1'b0}, // R9 approx with invalid
        '{1'b1, 32'h0004_0002, 1'b0, 5'b00000, 1'b0, 32'h0004_0002, 1'b0, 1'b0, 1'b1}, // R3 rm=10, R4 dn
        '{1'b0, 32'h0,         1'b1, 5'b01000, 1'b0, 32'h0004_8022, 1'b0, 1'b0, 1'b1}, // R7 not enabled
        '{1'b0, 32'h0,         1'b1, 5'b00011, 1'b0, 32'h0004_302E, 1'b0, 1'b0, 1'b1}, // R5 R6 accumulate
        '{1'b1, 32'h0000_0100, 1'b1, 5'b11111, 1'b0, 32'h0000_0100, 1'b0, 1'b0, 1'b0}, // R10 collision
        '{1'b0, 32'h0,         1'b1, 5'b00010, 1'b0, 32'h0000_2108, 1'b1, 1'b0, 1'b0}, // R7 underflow enabled
        '{1'b0, 32'h0,         1'b1, 5'b00001, 1'b0, 32'h0000_110C, 1'b0, 1'b0, 1'b0}, // R6 sticky keep
        '{1'b1, 32'h0000_0003, 1'b0, 5'b00000, 1'b0, 32'h0000_0003, 1'b0, 1'b0, 1'b0}, // R3 rm=11
        '{1'b1, 32'h0000_0000, 1'b0, 5'b00000, 1'b0, 32'h0000_0000, 1'b0, 1'b0, 1'b0}  // R2 clear
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        op_valid  = 1'b0;
        op_exc    = 5'b0;
        op_approx = 1'b0;
        sw_we     = 1'b0;
        sw_wdata  = 32'h0;
    endtask

    task automatic check_all(input logic [31:0] erd, input logic etr, input logic erz, input logic efl);
        check("R5 R6 R2 R11 rd_data", rd_data, erd);
        check("R7 trap_req", {31'b0, trap_req}, {31'b0, etr});
        check("R7 trap_code", {20'b0, trap_code}, etr ? 32'h120 : 32'h0);
        check("R3 rz_sel", {31'b0, rz_sel}, {31'b0, erz});
        check("R4 flush_sel", {31'b0, flush_sel}, {31'b0, efl});
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle_inputs();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        check_all(32'h0, 1'b0, 1'b0, 1'b0);
        rst = 1'b0;

        for (int n = 0; n < NV; n++) begin
            sw_we     = VECS[n].we;
            sw_wdata  = VECS[n].wd;
            op_valid  = VECS[n].ov;
            op_exc    = VECS[n].exc;
            op_approx = VECS[n].ap;
            @(negedge clk);
            idle_inputs();
            check_all(VECS[n].rd, VECS[n].tr, VECS[n].rz, VECS[n].fl);
        end

        // R7 trap lasts one cycle: trapping op, then idle
        sw_we = 1'b1; sw_wdata = 32'h0000_0800;
        @(negedge clk);
        idle_inputs();
        op_valid = 1'b1; op_exc = 5'b10000;
        @(negedge clk);
        idle_inputs();
        check("R7 trap raised", {31'b0, trap_req}, 32'h1);
        @(negedge clk);
        check("R7 trap single cycle", {31'b0, trap_req}, 32'h0);
        check("R7 idle keeps rd", rd_data, 32'h0001_0840);

        // R1 mid-run reset clears everything
        sw_we = 1'b1; sw_wdata = 32'h0004_0F81;
        @(negedge clk);
        idle_inputs();
        rst = 1'b1;
        @(negedge clk);
        check_all(32'h0, 1'b0, 1'b0, 1'b0);
        rst = 1'b0;
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule